// File: doc/BRIEF.md
# Synchronized Flash Pulse Generator

This block makes blink patterns for eight output channels, arranged as two groups of four. A slow flash-rate clock arrives from outside the system clock domain. The block resamples it on the fast system clock and detects its rising edges. For each group it divides that edge stream by a ratio of 1, 2, 4 or 16, chosen by a two-bit field of a control byte. The result is a square wave with a 50% duty cycle for that group.

Every channel has an output-configuration bit, a flash enable and a data bit. An output channel with flashing enabled drives its data ANDed with its group's flash wave. An output channel without flashing drives its data steadily. A channel that is not configured as an output drives low. The system clock has to run much faster than the flash-rate input, for example 2 MHz against 50 Hz, so that no level of the slow clock is missed.

Top module: `fpg_flash_gen`

## Requirements
- R1: While rst_n is low and in the cycles just after it, both flash waves are low. An output channel with flashing enabled drives 0, and an output channel without flashing drives its data bit.
- R2: flash_in passes through two system-clock flops and is compared with the value one flop later. A rising level that the bench drives before rising clock edge P0 shows on drive_out after edge P2, and each rising edge is counted exactly once.
- R3: The low group (channels 0 to 3) takes its ratio code from ctrl_byte bits 1 and 0. Bit 0 is the code's MSB and bit 1 is its LSB.
- R4: The high group (channels 4 to 7) takes its ratio code from ctrl_byte bits 5 and 4. Bit 4 is the code's MSB and bit 5 is its LSB.
- R5: The code maps to a ratio N: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 16. A group's flash wave inverts on every N-th detected rising edge of flash_in, so 32 rising edges after reset give 32/N inversions.
- R6: Falling edges of flash_in and the time flash_in stays high or low do not change the count. Only rising edges advance it.
- R7: An output channel (out_en=1) with pulse_en=1 drives data_in AND the flash wave of its group.
- R8: An output channel with pulse_en=0 drives data_in unchanged, whatever the state of the flash wave.
- R9: A channel with out_en=0 drives 0, whatever its data and enable bits are.
- R10: When a rising edge arrives and the edges already counted since the last inversion are at least N-1 for the current code, the wave inverts and the count restarts. This holds even when the code has just been lowered below the count.
- R11: ctrl_byte bits 2, 3, 6 and 7 have no effect on drive_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flash_in | input | 1 | Slow flash-rate clock, asynchronous to clk |
| ctrl_byte | input | 8 | Ratio codes, low group in bits 1:0 and high group in bits 5:4 |
| out_en | input | 8 | Per-channel output configuration |
| pulse_en | input | 8 | Per-channel flash enable |
| data_in | input | 8 | Per-channel data value |
| drive_out | output | 8 | Per-channel driven value |

## Verification
Two events can fall in the same cycle: a detected rising edge of flash_in and a change of a group's ratio code. The bench provokes this by switching the code from divide-by-16 to divide-by-2 in the exact cycle in which the edge pulse is high, after ten edges have already been counted. A behavioural model of the count decides whether the next clock edge inverts the wave, and its verdict is compared with drive_out on every cycle. A second overlap, a data or enable change in the same cycle as a flash inversion, is covered by changing the channel bits while flashing runs.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  localparam int unsigned CODE_W = 2;

  typedef logic [CODE_W-1:0] ratio_code_t;

  // Division ratio selected by a two-bit code.
  function automatic int unsigned ratio_of(ratio_code_t code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 16;
    endcase
  endfunction

  // The bit at the lower position is the code's MSB.
  function automatic ratio_code_t field_code(logic low_pos, logic high_pos);
    return {low_pos, high_pos};
  endfunction

endpackage

// File: rtl/fpg_sync_edge.sv
module fpg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              sync_level;

  assign sync_level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= sync_level;
    end
  end

  assign rise_pulse = sync_level & ~prev_q;
endmodule

// File: rtl/fpg_divider.sv
module fpg_divider
  import fpg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ratio_code_t      code,
  output logic             flash,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(ratio_of(code) - 1);
  assign wrap  = tick && (count >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flash <= 1'b0;
    end else if (tick) begin
      if (count >= limit) begin
        count <= '0;
        flash <= ~flash;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpg_chan_gate.sv
module fpg_chan_gate (
  input  logic data,
  input  logic is_output,
  input  logic flash_on,
  input  logic flash_wave,
  output logic drive
);
  always_comb begin
    if (!is_output)    drive = 1'b0;
    else if (flash_on) drive = data & flash_wave;
    else               drive = data;
  end
endmodule

// File: rtl/fpg_flash_gen.sv
module fpg_flash_gen
  import fpg_pkg::*;
#(
  parameter int NIBBLES     = 2,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flash_in,
  input  logic [NIBBLES*NIB_W-1:0] ctrl_byte,
  input  logic [NIBBLES*NIB_W-1:0] out_en,
  input  logic [NIBBLES*NIB_W-1:0] pulse_en,
  input  logic [NIBBLES*NIB_W-1:0] data_in,
  output logic [NIBBLES*NIB_W-1:0] drive_out
);
  localparam int CH = NIBBLES * NIB_W;

  logic                     rise_pulse;
  logic [NIBBLES-1:0]       flash_vec;
  logic [NIBBLES-1:0]       wrap_vec;
  logic [NIBBLES*CNT_W-1:0] cnt_flat;

  fpg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (flash_in),
    .rise_pulse(rise_pulse)
  );

  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
    ratio_code_t code;
    assign code = field_code(ctrl_byte[n*NIB_W], ctrl_byte[n*NIB_W+1]);

    fpg_divider #(.CNT_W(CNT_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (rise_pulse),
      .code (code),
      .flash(flash_vec[n]),
      .count(cnt_flat[n*CNT_W +: CNT_W]),
      .wrap (wrap_vec[n])
    );
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    fpg_chan_gate u_gate (
      .data      (data_in[i]),
      .is_output (out_en[i]),
      .flash_on  (pulse_en[i]),
      .flash_wave(flash_vec[i / NIB_W]),
      .drive     (drive_out[i])
    );
  end
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int NIBBLES = 2,
  parameter int NIB_W   = 4,
  parameter int CNT_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rise_pulse,
  input logic [NIBBLES-1:0]       flash_vec,
  input logic [NIBBLES-1:0]       wrap_vec,
  input logic [NIBBLES*CNT_W-1:0] cnt_flat,
  input logic [NIBBLES*NIB_W-1:0] out_en,
  input logic [NIBBLES*NIB_W-1:0] pulse_en,
  input logic [NIBBLES*NIB_W-1:0] data_in,
  input logic [NIBBLES*NIB_W-1:0] drive_out
);
  localparam int CH = NIBBLES * NIB_W;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R2

  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib_chk
    AST_TOGGLE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flash_vec[n]) |-> $past(rise_pulse)); // R5

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_pulse |=> $stable(cnt_flat[n*CNT_W +: CNT_W])); // R6

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[n] |=> (flash_vec[n] != $past(flash_vec[n])) &&
                      (cnt_flat[n*CNT_W +: CNT_W] == '0)); // R10
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch_chk
    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en[i] && pulse_en[i] && !flash_vec[i / NIB_W]) |-> !drive_out[i]); // R7

    AST_STEADY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en[i] && !pulse_en[i]) |-> (drive_out[i] == data_in[i])); // R8

    AST_INPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[i] |-> !drive_out[i]); // R9
  end
endmodule

bind fpg_flash_gen fpg_checker #(
  .NIBBLES(NIBBLES),
  .NIB_W  (NIB_W),
  .CNT_W  (CNT_W)
) u_fpg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_pulse(rise_pulse),
  .flash_vec (flash_vec),
  .wrap_vec  (wrap_vec),
  .cnt_flat  (cnt_flat),
  .out_en    (out_en),
  .pulse_en  (pulse_en),
  .data_in   (data_in),
  .drive_out (drive_out)
);

// File: tb/fpg_flash_gen_bench.sv
`timescale 1ns/1ps
module fpg_flash_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flash_in = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic [7:0] out_en = 8'hFF;
  logic [7:0] pulse_en = 8'hFF;
  logic [7:0] data_in = 8'hFF;
  logic [7:0] drive_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  fpg_flash_gen u_fpg_flash_gen (
    .clk(clk), .rst_n(rst_n), .flash_in(flash_in), .ctrl_byte(ctrl_byte),
    .out_en(out_en), .pulse_en(pulse_en), .data_in(data_in), .drive_out(drive_out)
  );

  // Behavioural reference: a history of samples and an edge tally per group.
  bit m_hist[$] = '{0, 0, 0};
  int m_seen[2] = '{0, 0};
  bit m_wave[2] = '{0, 0};

  function automatic int ratio_from_ctrl(logic [7:0] c, int grp);
    int code = (c[4*grp] ? 2 : 0) + (c[4*grp+1] ? 1 : 0);
    return (code == 3) ? 16 : (1 << code);
  endfunction

  function automatic logic [7:0] mk_ctrl(logic [1:0] lo, logic [1:0] hi, logic [7:0] junk);
    logic [7:0] r = junk & 8'hCC;
    r[0] = lo[1]; r[1] = lo[0]; r[4] = hi[1]; r[5] = hi[0];
    return r;
  endfunction

  function automatic logic [7:0] model_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (!out_en[i])       r[i] = 1'b0;
      else if (pulse_en[i]) r[i] = data_in[i] & m_wave[i / 4];
      else                  r[i] = data_in[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist = '{0, 0, 0};
      m_seen = '{0, 0};
      m_wave = '{0, 0};
    end else begin
      // m_hist[0] newest sample, [1] settled level, [2] level one cycle older
      if (m_hist[1] && !m_hist[2]) begin
        for (int g = 0; g < 2; g++) begin
          if (m_seen[g] + 1 >= ratio_from_ctrl(ctrl_byte, g)) begin
            m_seen[g] = 0;
            m_wave[g] = !m_wave[g];
          end else begin
            m_seen[g]++;
          end
        end
      end
      m_hist.push_front(flash_in);
      void'(m_hist.pop_back());
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) check({phase, " model"}, drive_out, model_out());

  // Inversion counters for the divide checks.
  bit counting = 0;
  int tog_lo = 0, tog_hi = 0;
  logic last_lo, last_hi;
  always @(negedge clk) if (counting) begin
    if (drive_out[0] !== last_lo) tog_lo++;
    if (drive_out[4] !== last_hi) tog_hi++;
    last_lo = drive_out[0];
    last_hi = drive_out[4];
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic periods(int k, int hi_len, int lo_len);
    repeat (k) begin
      flash_in = 1'b1; step(hi_len);
      flash_in = 1'b0; step(lo_len);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; flash_in = 1'b0; step(3);
    rst_n = 1'b1; step(1);
  endtask

  task automatic divide_check(logic [1:0] lo, logic [1:0] hi, logic [7:0] junk, string tag);
    ctrl_byte = mk_ctrl(lo, hi, junk);
    out_en = 8'hFF; pulse_en = 8'hFF; data_in = 8'hFF;
    do_reset();
    tog_lo = 0; tog_hi = 0; last_lo = drive_out[0]; last_hi = drive_out[4];
    counting = 1;
    periods(32, 3 + lo, 9 + hi);
    step(5);
    counting = 0;
    check({tag, " R3 R5 R6 low group"}, 8'(tog_lo), 8'(32 / ratio_from_ctrl(ctrl_byte, 0)));
    check({tag, " R4 R5 R6 high group"}, 8'(tog_hi), 8'(32 / ratio_from_ctrl(ctrl_byte, 1)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(2);
    check("R1 flashing channels low in reset", drive_out, 8'h00);
    pulse_en = 8'h0F; data_in = 8'hA5; step(1);
    check("R1 steady channels pass in reset", drive_out, 8'hA0);
    rst_n = 1'b1; step(1);
    check("R1 after release", drive_out, 8'hA0);
    cmp_on = 1;

    // R2: two-flop latency, undivided
    phase = "R2";
    pulse_en = 8'hFF; data_in = 8'hFF; ctrl_byte = 8'h00;
    flash_in = 1'b1; step(1);
    check("R2 after P0", drive_out, 8'h00);
    step(1);
    check("R2 after P1", drive_out, 8'h00);
    step(1);
    check("R2 after P2", drive_out, 8'hFF);
    step(20);
    check("R2 long high counted once", drive_out, 8'hFF);

    // R3 R4 R5 R6: every code in both groups
    phase = "R5";
    divide_check(2'd0, 2'd3, 8'h00, "code0/3");
    divide_check(2'd1, 2'd2, 8'h00, "code1/2");
    divide_check(2'd2, 2'd1, 8'h00, "code2/1");
    divide_check(2'd3, 2'd0, 8'h00, "code3/0");
    // R11: unused bits set
    phase = "R11";
    divide_check(2'd1, 2'd2, 8'hCC, "R11 junk bits");

    // R10: code lowered in the very cycle of an edge pulse
    phase = "R10";
    ctrl_byte = mk_ctrl(2'd3, 2'd3, 8'h00);
    do_reset();
    periods(10, 4, 6);
    check("R10 before switch", drive_out, 8'h00);
    flash_in = 1'b1; step(2);           // edge pulse high in this cycle
    ctrl_byte = mk_ctrl(2'd1, 2'd3, 8'h00);
    step(1);
    check("R10 low group inverts on lowered code", drive_out, 8'h0F);
    flash_in = 1'b0; step(6);

    // R7 R8 R9: channel patterns during flashing
    phase = "R7 R8 R9";
    ctrl_byte = mk_ctrl(2'd0, 2'd1, 8'h00);
    for (int p = 0; p < 12; p++) begin
      out_en   = 8'(8'hF3 ^ (p * 37));
      pulse_en = 8'(8'h5A + p * 19);
      data_in  = 8'(8'hC3 ^ (p * 11));
      periods(1, 3 + p % 4, 5);
    end
    out_en = 8'h00; data_in = 8'hFF; pulse_en = 8'h0F; step(2);
    check("R9 inputs drive low", drive_out, 8'h00);
    out_en = 8'hFF; pulse_en = 8'h00; data_in = 8'h3C; step(2);
    check("R8 steady data", drive_out, 8'h3C);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule